// File: doc/BRIEF.md
# Block Load/Store Micro-Op Sequencer

This block breaks one multi-register load or store instruction into a series of single-word micro-operations. It produces one per handshake. A start pulse, taken only while the block is idle, captures the following inputs:

- a register mask
- the base register index
- direction, pre-index, writeback, load and user/status flags

The block then emits its micro-ops one at a time on a valid/ready output. Each micro-op carries an operation kind, a register index, a base index, a byte offset, a user-bank flag and a final-op flag.

The sequence always starts with a hidden copy of the base register into a temporary register, index 16. All transfers address through that temporary. One transfer is emitted per set mask bit, from the lowest register to the highest. When writeback is requested, a base update follows the transfers. When the user/status flag is set, the block does one of two things. If register 15 is in the mask, a load of register 15 becomes a return-load that also restores the status register. If register 15 is absent, every transfer is marked for the user register bank.

The controller has four states:

- `S_IDLE`: waiting for a start.
- `S_COPY`: presenting the base copy.
- `S_XFER`: presenting transfers.
- `S_WBACK`: presenting the base update.

Its transitions are:

- idle→copy on start.
- copy→xfer when the mask is non-empty.
- copy→wback when the mask is empty and writeback is set.
- copy→idle when the mask is empty and writeback is clear.
- xfer→xfer while mask bits remain.
- xfer→wback after the last transfer when writeback is set.
- xfer→idle after the last transfer when writeback is clear.
- wback→idle.

Every transition out of copy, xfer or wback happens only on an accepted micro-op.

Top module: `lsm_uop_seq`

## Requirements
- R1: After reset, `uop_valid_o` and `busy_o` are low.
- R2: Start is taken only in `S_IDLE`. A start raised while busy has no effect on the micro-ops emitted. `busy_o` equals `uop_valid_o`, and both rise in the cycle after an accepted start.
- R3: The first micro-op has kind 0 (copy), register 16, base equal to the base index, and offset 0.
- R4: One transfer is emitted per set mask bit, in increasing register order. Each transfer has base 16 and its register in the register field. Its kind is 1 (load) or 3 (store).
- R5: The first transfer offset is 0 when counting up, and 4×N−4 when counting down, where N is the number of set bits. The pre-index flag adds 4.
- R6: Each following transfer offset is the previous one +4 when counting up and −4 when counting down.
- R7: With writeback, a final micro-op of kind 4 (add, counting up) or kind 5 (subtract, counting down) is emitted. Its register and base both equal the base index, and its offset is 4×N.
- R8: `uop_last_o` is high on the final micro-op of each sequence and low on all others.
- R9: With the user/status flag, a load and register 15 in the mask, the register-15 transfer has kind 2 (return-load). Other loads keep kind 1, and `uop_ubank_o` stays low.
- R10: With the user/status flag and register 15 not in the mask, `uop_ubank_o` is high on every transfer. It is low in all other cases.
- R11: An empty mask yields only the copy and, when writeback is set, the base update with offset 0.
- R12: While `uop_valid_o` is high and `uop_ready_i` is low, all micro-op outputs hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request to begin a new instruction |
| reg_list_i | input | 16 | Register mask, bit k selects register k |
| base_idx_i | input | 4 | Base register index |
| up_i | input | 1 | 1 = count upward, 0 = downward |
| pre_i | input | 1 | Pre-index flag, adds 4 to the start offset |
| wb_i | input | 1 | Base writeback request |
| load_i | input | 1 | 1 = load, 0 = store |
| usr_i | input | 1 | User-bank / status-restore flag |
| busy_o | output | 1 | A sequence is in progress |
| uop_valid_o | output | 1 | Micro-op present |
| uop_ready_i | input | 1 | Downstream accepts the micro-op |
| uop_kind_o | output | 3 | 0 copy, 1 load, 2 return-load, 3 store, 4 base add, 5 base subtract |
| uop_reg_o | output | 5 | Destination/source register (16 = temporary) |
| uop_base_o | output | 5 | Base register of the micro-op |
| uop_offset_o | output | 7 | Byte offset or writeback amount |
| uop_ubank_o | output | 1 | Register belongs to the user bank |
| uop_last_o | output | 1 | Final micro-op of the sequence |

## Verification
The embedded properties assume that `uop_ready_i` is a plain level chosen freely by the consumer. They also assume that the instruction fields matter only in the cycle a start is taken, so fields that change while busy must not disturb the sequence.

The bench drives ready from a pseudo-random bit for most sequences, which exercises stalls on every kind of micro-op. It changes the fields only together with start, and on purpose raises a start with a different mask in the middle of a sequence. The reference model builds each expected sequence from the requirements. It compares the head of the model queue against the ports on every cycle.

// File: rtl/lsm_pkg.sv
package lsm_pkg;

    typedef enum logic [2:0] {
        K_COPY    = 3'd0,
        K_LOAD    = 3'd1,
        K_LOADRET = 3'd2,
        K_STORE   = 3'd3,
        K_BASEADD = 3'd4,
        K_BASESUB = 3'd5
    } uop_kind_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_COPY,
        S_XFER,
        S_WBACK
    } seq_state_e;

endpackage

// File: rtl/lsm_popcnt.sv
module lsm_popcnt #(
    parameter int W = 16,
    localparam int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec_i,
    output logic [CW-1:0] cnt_o
);
    always_comb begin
        cnt_o = '0;
        for (int i = 0; i < W; i++) begin
            cnt_o = cnt_o + CW'(vec_i[i]);
        end
    end
endmodule

// File: rtl/lsm_lowbit.sv
module lsm_lowbit #(
    parameter int W = 16,
    localparam int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec_i,
    output logic [IW-1:0] idx_o,
    output logic [W-1:0]  rest_o
);
    // lowest set bit wins; the remainder has that bit cleared
    always_comb begin
        idx_o = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec_i[i]) idx_o = IW'(i);
        end
    end

    assign rest_o = vec_i & (vec_i - W'(1));
endmodule

// File: rtl/lsm_uop_seq.sv
module lsm_uop_seq
    import lsm_pkg::*;
#(
    parameter int LIST_W     = 16,
    parameter int WORD_BYTES = 4,
    localparam int IDX_W     = $clog2(LIST_W),
    localparam int REG_W     = IDX_W + 1,
    localparam int OFF_W     = $clog2(LIST_W * WORD_BYTES + 1),
    localparam int CNT_W     = $clog2(LIST_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [LIST_W-1:0] reg_list_i,
    input  logic [IDX_W-1:0]  base_idx_i,
    input  logic              up_i,
    input  logic              pre_i,
    input  logic              wb_i,
    input  logic              load_i,
    input  logic              usr_i,
    output logic              busy_o,
    output logic              uop_valid_o,
    input  logic              uop_ready_i,
    output logic [2:0]        uop_kind_o,
    output logic [REG_W-1:0]  uop_reg_o,
    output logic [REG_W-1:0]  uop_base_o,
    output logic [OFF_W-1:0]  uop_offset_o,
    output logic              uop_ubank_o,
    output logic              uop_last_o
);
    localparam int PC_IDX = LIST_W - 1;
    localparam logic [REG_W-1:0] TEMP_IDX = REG_W'(LIST_W);
    localparam int OX = OFF_W + 1;
    localparam logic [OFF_W-1:0] STEP = OFF_W'(WORD_BYTES);

    seq_state_e state_q, state_d;

    logic [LIST_W-1:0] list_q;
    logic [IDX_W-1:0]  base_q;
    logic              up_q, wb_q, load_q, usr_q, pcin_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [OFF_W-1:0]  off_q;

    logic [CNT_W-1:0]  in_cnt;
    logic [IDX_W-1:0]  low_idx;
    logic [LIST_W-1:0] rest;
    logic [OX-1:0]     start_off;
    logic              fire;
    uop_kind_e         kind;

    lsm_popcnt #(.W(LIST_W)) u_popcnt (
        .vec_i (reg_list_i),
        .cnt_o (in_cnt)
    );

    lsm_lowbit #(.W(LIST_W)) u_lowbit (
        .vec_i  (list_q),
        .idx_o  (low_idx),
        .rest_o (rest)
    );

    // start offset: up -> 0, down -> N*W-W, pre-index adds one word
    always_comb begin
        start_off = up_i ? '0
                  : (OX'(in_cnt) * OX'(WORD_BYTES) - OX'(WORD_BYTES));
        if (pre_i) start_off = start_off + OX'(WORD_BYTES);
    end

    assign fire = uop_valid_o & uop_ready_i;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (start_i) state_d = S_COPY;
            S_COPY:  if (fire) begin
                         if (list_q != '0) state_d = S_XFER;
                         else if (wb_q)    state_d = S_WBACK;
                         else              state_d = S_IDLE;
                     end
            S_XFER:  if (fire && rest == '0) state_d = wb_q ? S_WBACK : S_IDLE;
            S_WBACK: if (fire) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // captured instruction and running scan state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            list_q <= '0;
            base_q <= '0;
            up_q   <= 1'b0;
            wb_q   <= 1'b0;
            load_q <= 1'b0;
            usr_q  <= 1'b0;
            pcin_q <= 1'b0;
            cnt_q  <= '0;
            off_q  <= '0;
        end else if (state_q == S_IDLE && start_i) begin
            list_q <= reg_list_i;
            base_q <= base_idx_i;
            up_q   <= up_i;
            wb_q   <= wb_i;
            load_q <= load_i;
            usr_q  <= usr_i;
            pcin_q <= reg_list_i[PC_IDX];
            cnt_q  <= in_cnt;
            off_q  <= start_off[OFF_W-1:0];
        end else if (state_q == S_XFER && fire) begin
            list_q <= rest;
            off_q  <= up_q ? off_q + STEP : off_q - STEP;
        end
    end

    // outputs
    always_comb begin
        uop_valid_o  = 1'b0;
        kind         = K_COPY;
        uop_reg_o    = '0;
        uop_base_o   = '0;
        uop_offset_o = '0;
        uop_ubank_o  = 1'b0;
        uop_last_o   = 1'b0;
        unique case (state_q)
            S_IDLE: ;
            S_COPY: begin
                uop_valid_o = 1'b1;
                kind        = K_COPY;
                uop_reg_o   = TEMP_IDX;
                uop_base_o  = {1'b0, base_q};
                uop_last_o  = (list_q == '0) && !wb_q;
            end
            S_XFER: begin
                uop_valid_o  = 1'b1;
                if (!load_q)                                      kind = K_STORE;
                else if (usr_q && pcin_q && low_idx == IDX_W'(PC_IDX)) kind = K_LOADRET;
                else                                              kind = K_LOAD;
                uop_reg_o    = {1'b0, low_idx};
                uop_base_o   = TEMP_IDX;
                uop_offset_o = off_q;
                uop_ubank_o  = usr_q && !pcin_q;
                uop_last_o   = (rest == '0) && !wb_q;
            end
            S_WBACK: begin
                uop_valid_o  = 1'b1;
                kind         = up_q ? K_BASEADD : K_BASESUB;
                uop_reg_o    = {1'b0, base_q};
                uop_base_o   = {1'b0, base_q};
                uop_offset_o = OFF_W'(cnt_q) * OFF_W'(WORD_BYTES);
                uop_last_o   = 1'b1;
            end
            default: ;
        endcase
    end

    assign uop_kind_o = kind;
    assign busy_o     = (state_q != S_IDLE);

    // ---------------- assertions ----------------
    logic is_xfer;
    assign is_xfer = uop_valid_o &&
                     (uop_kind_o == K_LOAD || uop_kind_o == K_LOADRET || uop_kind_o == K_STORE);

    assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_valid_o && !uop_ready_i) |=> (uop_valid_o && $stable(uop_kind_o) &&
            $stable(uop_reg_o) && $stable(uop_base_o) && $stable(uop_offset_o) &&
            $stable(uop_ubank_o) && $stable(uop_last_o)));

    assert_copy_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> (uop_kind_o == K_COPY && uop_reg_o == TEMP_IDX && uop_offset_o == '0));

    assert_xfer_base_R4: assert property (@(posedge clk) disable iff (!rst_n)
        is_xfer |-> (uop_base_o == TEMP_IDX));

    assert_offset_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && is_xfer) |=> (!is_xfer ||
            uop_offset_o == (up_q ? $past(uop_offset_o) + STEP : $past(uop_offset_o) - STEP)));

    assert_last_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && uop_last_o) |=> !uop_valid_o);

    assert_wb_final_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_valid_o && (uop_kind_o == K_BASEADD || uop_kind_o == K_BASESUB)) |-> uop_last_o);

    assert_ret_pc_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_valid_o && uop_kind_o == K_LOADRET) |-> (uop_reg_o == REG_W'(PC_IDX) && !uop_ubank_o));

    assert_busy_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o == uop_valid_o);
endmodule

// File: tb/test_lsm_uop_seq.sv
module test_lsm_uop_seq;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n, start_i, up_i, pre_i, wb_i, load_i, usr_i, uop_ready_i;
    logic [15:0] reg_list_i;
    logic [3:0]  base_idx_i;
    logic        busy_o, uop_valid_o, uop_ubank_o, uop_last_o;
    logic [2:0]  uop_kind_o;
    logic [4:0]  uop_reg_o, uop_base_o;
    logic [6:0]  uop_offset_o;

    lsm_uop_seq i_lsm_uop_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .reg_list_i(reg_list_i),
        .base_idx_i(base_idx_i), .up_i(up_i), .pre_i(pre_i), .wb_i(wb_i),
        .load_i(load_i), .usr_i(usr_i), .busy_o(busy_o), .uop_valid_o(uop_valid_o),
        .uop_ready_i(uop_ready_i), .uop_kind_o(uop_kind_o), .uop_reg_o(uop_reg_o),
        .uop_base_o(uop_base_o), .uop_offset_o(uop_offset_o),
        .uop_ubank_o(uop_ubank_o), .uop_last_o(uop_last_o)
    );

    int checks = 0;
    int failures = 0;
    logic [21:0] exp_q[$];
    logic [15:0] lfsr = 16'hACE1;
    logic        stall_mode = 1'b0;
    logic        prev_valid = 1'b0, prev_ready = 1'b0;
    logic [21:0] prev_word = '0;
    string       tag = "R1";

    // pending start request for the next tick
    logic        req_start = 1'b0;
    logic [15:0] req_list;
    logic [3:0]  req_base;
    logic        req_up, req_pre, req_wb, req_ld, req_usr;

    function automatic logic [21:0] pack(logic [2:0] k, logic [4:0] r, logic [4:0] b,
                                         logic [6:0] o, logic ub, logic l);
        return {k, r, b, o, ub, l};
    endfunction

    task automatic check(string req, logic [21:0] act, logic [21:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // reference: builds the whole expected sequence from the requirements
    task automatic model_push(logic [15:0] lst, logic [3:0] b, logic up, logic pre,
                              logic wb, logic ld, logic usr);
        int n = 0, seen = 0, off;
        logic pcin = lst[15];
        for (int i = 0; i < 16; i++) n += int'(lst[i]);
        exp_q.push_back(pack(3'd0, 5'd16, {1'b0, b}, 7'd0, 1'b0, (n == 0) && !wb)); // R3, R11
        off = up ? 0 : 4 * n - 4;                                                  // R5
        if (pre) off += 4;
        for (int i = 0; i < 16; i++) begin
            if (lst[i]) begin
                logic [2:0] k;
                seen++;
                if (!ld) k = 3'd3;
                else if (usr && pcin && i == 15) k = 3'd2;                          // R9
                else k = 3'd1;
                exp_q.push_back(pack(k, 5'(i), 5'd16, 7'(off), usr && !pcin,        // R4, R10
                                     (seen == n) && !wb));                           // R8
                off = up ? off + 4 : off - 4;                                       // R6
            end
        end
        if (wb) exp_q.push_back(pack(up ? 3'd4 : 3'd5, {1'b0, b}, {1'b0, b},        // R7
                                     7'(4 * n), 1'b0, 1'b1));
    endtask

    task automatic tick();
        logic [21:0] word;
        logic was_idle, r;
        @(negedge clk);
        word = pack(uop_kind_o, uop_reg_o, uop_base_o, uop_offset_o, uop_ubank_o, uop_last_o);
        was_idle = (exp_q.size() == 0);
        // R2: valid and busy follow the model's occupancy
        check("R2 valid", {21'd0, uop_valid_o}, {21'd0, !was_idle});
        check("R2 busy",  {21'd0, busy_o},      {21'd0, !was_idle});
        if (!was_idle && uop_valid_o) check(tag, word, exp_q[0]);
        if (prev_valid && !prev_ready) check("R12 hold", word, prev_word);
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        r = stall_mode ? lfsr[0] : 1'b1;
        uop_ready_i = r;
        if (!was_idle && r) void'(exp_q.pop_front());
        start_i = req_start;
        if (req_start) begin
            reg_list_i = req_list; base_idx_i = req_base; up_i = req_up; pre_i = req_pre;
            wb_i = req_wb; load_i = req_ld; usr_i = req_usr;
            if (was_idle) model_push(req_list, req_base, req_up, req_pre, req_wb, req_ld, req_usr);
        end
        prev_valid = uop_valid_o;
        prev_ready = r;
        prev_word  = word;
    endtask

    task automatic do_op(string t, logic [15:0] lst, logic [3:0] b, logic up, logic pre,
                         logic wb, logic ld, logic usr, logic stall, logic poke);
        tag = t;
        stall_mode = stall;
        req_start = 1'b1; req_list = lst; req_base = b; req_up = up; req_pre = pre;
        req_wb = wb; req_ld = ld; req_usr = usr;
        tick();
        req_start = 1'b0;
        for (int c = 0; c < 300 && exp_q.size() != 0; c++) begin
            if (poke && c == 2) begin
                // R2: start with another mask while busy must be ignored
                req_start = 1'b1; req_list = 16'h0003; req_base = 4'd9; req_up = 1'b0;
                req_wb = 1'b1;
            end else begin
                req_start = 1'b0;
            end
            tick();
        end
        req_start = 1'b0;
        tick();
        tick();
    endtask

    initial begin
        rst_n = 1'b0; start_i = 1'b0; uop_ready_i = 1'b0; reg_list_i = '0; base_idx_i = '0;
        up_i = 1'b0; pre_i = 1'b0; wb_i = 1'b0; load_i = 1'b0; usr_i = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 valid", {21'd0, uop_valid_o}, 22'd0);
        check("R1 busy",  {21'd0, busy_o},      22'd0);
        rst_n = 1'b1;
        tick();
        do_op("R4 R5 up load wb",      16'h00F1, 4'd2,  1, 0, 1, 1, 0, 0, 0);
        do_op("R5 R6 down pre store",  16'h8421, 4'd13, 0, 1, 1, 0, 0, 1, 0);
        do_op("R6 R8 down full load",  16'hFFFF, 4'd0,  0, 0, 0, 1, 0, 1, 0);
        do_op("R5 up pre store",       16'h0A0A, 4'd7,  1, 1, 0, 0, 0, 1, 0);
        do_op("R11 empty wb",          16'h0000, 4'd5,  1, 0, 1, 1, 0, 0, 0);
        do_op("R11 empty nowb",        16'h0000, 4'd5,  0, 0, 0, 1, 0, 1, 0);
        do_op("R11 empty wb down",     16'h0000, 4'd3,  0, 1, 1, 0, 0, 1, 0);
        do_op("R9 return load",        16'h8003, 4'd1,  1, 0, 1, 1, 1, 1, 0);
        do_op("R10 user bank store",   16'h0F00, 4'd4,  0, 1, 0, 0, 1, 1, 0);
        do_op("R10 user bank load",    16'h4001, 4'd6,  1, 0, 1, 1, 1, 0, 0);
        do_op("R9 store pc usr",       16'h8001, 4'd8,  1, 0, 0, 0, 1, 1, 0);
        do_op("R2 start while busy",   16'h0130, 4'd11, 1, 1, 1, 1, 0, 1, 1);
        do_op("R12 single pc load",    16'h8000, 4'd14, 0, 0, 1, 1, 0, 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule